// File: doc/BRIEF.md
# Modulo 2^W-1 Triple Hard Multiple Generator

This block produces the residue of three times an operand modulo 2^W-1, the "hard" multiple that a radix-8 signed-digit multiplier cannot form with a plain shift. It does so without a second adder pass. Doubling modulo 2^W-1 is a one-bit cyclic rotation. The block adds the operand to its rotated copy in a single end-around-carry adder, whose carry out of the top bit re-enters at bit 0.

The adder is built in three layers. A bitwise layer forms generate, propagate and half-sum bits. A ring-shaped prefix network gives every bit a carry that spans all W positions around the ring. A final layer XORs each half-sum with the carry from the bit below, taking the wrap into account. The network comes in two variants, chosen by a parameter: a log-depth ring and a serial ring. A mode input turns the same datapath into a general two-operand adder modulo 2^W-1, so that the multiplier's final adder can reuse it. The block is purely combinational. Zero has two legal encodings, all zeros and all ones.

Top module: `modm_triple_hmg`

## Requirements
- R1: With `mode` = 0 (triple), `result` equals the end-around-carry sum of `op_a` and `op_a` rotated left by one bit. This is congruent to 3·`op_a` modulo 2^W-1.
- R2: With `mode` = 1 (add), `result` equals the end-around-carry sum of `op_a` and `op_b`: the low W bits of the sum plus the carry out of the top bit. This is congruent to `op_a`+`op_b` modulo 2^W-1.
- R3: With `mode` = 0, `op_b` has no effect on `result`.
- R4: `result` is all ones exactly when the exact integer sum of the two effective operands is nonzero and a multiple of 2^W-1. It is all zeros exactly when that sum is zero.
- R5: The log-depth ring variant (`PREFIX_ARCH` = 0) and the serial ring variant (`PREFIX_ARCH` = 1) produce identical `result` for every input.
- R6: `result` follows the inputs within the same cycle, because the block holds no state.
- R7: Elaboration fails when `WIDTH` is below 2 or when `PREFIX_ARCH` is not 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 1 | 0 = form 3·op_a, 1 = add op_a and op_b |
| op_a | input | WIDTH | Operand residue (the multiplicand in triple mode) |
| op_b | input | WIDTH | Second addend, used only in add mode |
| result | output | WIDTH | Residue modulo 2^WIDTH-1, with zero as all zeros or all ones |

## Verification
The bound checker evaluates the exact end-around-carry value on every input change in both modes. It also checks the congruence to 3·op_a and the two-encoding rule for zero, so every applied vector is covered by R1, R2 and R4. Only the bench scenarios can show that op_b is really ignored in triple mode: this needs the same op_a held while op_b varies. The agreement of the two prefix variants likewise needs both instances driven side by side. The bench sweeps every 8-bit operand in triple mode, adds random and corner pairs in add mode, and checks all of these.

// File: rtl/modm_hmg_pkg.sv
package modm_hmg_pkg;

   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   typedef enum logic {
      MODE_TRIPLE = 1'b0,
      MODE_ADD    = 1'b1
   } op_mode_e;

   localparam int ARCH_RING_LOG    = 0;
   localparam int ARCH_RING_SERIAL = 1;

   // Prefix operator: the upper group absorbs the lower one.
   function automatic gp_t gp_join(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

   // Cyclic index (i - d) mod w for non-negative results.
   function automatic int ring_idx(input int i, input int d, input int w);
      return (((i - d) % w) + w) % w;
   endfunction

endpackage

// File: rtl/modm_preproc.sv
module modm_preproc #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] g,
   output logic [W-1:0] p,
   output logic [W-1:0] h
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign g[i] = a[i] & b[i];
      assign p[i] = a[i] | b[i];
      assign h[i] = a[i] ^ b[i];
   end
endmodule

// File: rtl/modm_ring_prefix.sv
module modm_ring_prefix
   import modm_hmg_pkg::*;
#(
   parameter int W    = 8,
   parameter int ARCH = ARCH_RING_LOG
) (
   input  logic [W-1:0] g,
   input  logic [W-1:0] p,
   output logic [W-1:0] c   // c[i] = carry leaving bit i, wrap included
);
   localparam int LEVELS = (W < 2) ? 1 : $clog2(W);

   if (ARCH == ARCH_RING_LOG) begin : g_log
      // Each level doubles the span; after LEVELS levels every span covers the ring.
      logic [W-1:0] gc, pc, gn, pn;
      always_comb begin
         gc = g;
         pc = p;
         gn = g;
         pn = p;
         for (int lv = 0; lv < LEVELS; lv++) begin
            for (int i = 0; i < W; i++) begin
               gp_t node;
               node = gp_join(gp_t'{g: gc[i], p: pc[i]},
                              gp_t'{g: gc[ring_idx(i, 1 << lv, W)],
                                    p: pc[ring_idx(i, 1 << lv, W)]});
               gn[i] = node.g;
               pn[i] = node.p;
            end
            gc = gn;
            pc = pn;
         end
         c = gc;
      end
   end else begin : g_serial
      // Group generate of the whole word gives the wrapped carry into bit 0,
      // then one ripple pass around the ring.
      logic wrap_c, run_c;
      always_comb begin
         wrap_c = 1'b0;
         for (int i = 0; i < W; i++) begin
            wrap_c = g[i] | (p[i] & wrap_c);
         end
         run_c = wrap_c;
         c = '0;
         for (int i = 0; i < W; i++) begin
            c[i]  = g[i] | (p[i] & run_c);
            run_c = c[i];
         end
      end
   end
endmodule

// File: rtl/modm_postproc.sv
module modm_postproc #(
   parameter int W = 8
) (
   input  logic [W-1:0] h,
   input  logic [W-1:0] c,
   output logic [W-1:0] s
);
   for (genvar i = 0; i < W; i++) begin : g_sum
      assign s[i] = h[i] ^ c[(i + W - 1) % W];
   end
endmodule

// File: rtl/modm_triple_hmg.sv
module modm_triple_hmg
   import modm_hmg_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int PREFIX_ARCH = ARCH_RING_LOG
) (
   input  logic             mode,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH-1:0] result
);
   // R7: elaboration-time parameter checks
   if (WIDTH < 2) begin : g_bad_width
      $error("modm_triple_hmg: WIDTH must be at least 2");
   end
   if (PREFIX_ARCH != ARCH_RING_LOG && PREFIX_ARCH != ARCH_RING_SERIAL) begin : g_bad_arch
      $error("modm_triple_hmg: PREFIX_ARCH must be 0 or 1");
   end

   logic [WIDTH-1:0] dbl_a, addend;
   logic [WIDTH-1:0] gen_v, prop_v, half_v, carry_v;

   // Doubling modulo 2^W-1 is a left rotation by one.
   assign dbl_a  = {op_a[WIDTH-2:0], op_a[WIDTH-1]};
   assign addend = (op_mode_e'(mode) == MODE_ADD) ? op_b : dbl_a;

   modm_preproc #(.W(WIDTH)) u_pre (
      .a (op_a),
      .b (addend),
      .g (gen_v),
      .p (prop_v),
      .h (half_v)
   );

   modm_ring_prefix #(.W(WIDTH), .ARCH(PREFIX_ARCH)) u_tree (
      .g (gen_v),
      .p (prop_v),
      .c (carry_v)
   );

   modm_postproc #(.W(WIDTH)) u_post (
      .h (half_v),
      .c (carry_v),
      .s (result)
   );
endmodule

// File: rtl/modm_hmg_chk.sv
module modm_hmg_chk #(
   parameter int WIDTH = 8
) (
   input logic             mode,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [WIDTH-1:0] result
);
   localparam logic [WIDTH:0] MOD = {1'b0, {WIDTH{1'b1}}};

   logic [WIDTH-1:0] other;
   logic [WIDTH:0]   full_sum;
   logic [WIDTH:0]   eac_sum;
   logic [WIDTH+2:0] three_a;
   logic [WIDTH+2:0] modv;

   always_comb begin
      other    = mode ? op_b : {op_a[WIDTH-2:0], op_a[WIDTH-1]};
      full_sum = {1'b0, op_a} + {1'b0, other};
      eac_sum  = {1'b0, full_sum[WIDTH-1:0]} + {{WIDTH{1'b0}}, full_sum[WIDTH]};
      three_a  = 3 * {3'b000, op_a};
      modv     = {2'b00, MOD};
      if (!$isunknown({mode, op_a, op_b, result})) begin
         // R1 / R2: exact end-around-carry value
         p_eac_value_r2: assert (result == eac_sum[WIDTH-1:0])
            else $error("checker: result %h expected %h", result, eac_sum[WIDTH-1:0]);
         // R1: triple congruence
         p_triple_congr_r1: assert (mode || ({3'b000, result} % modv) == (three_a % modv))
            else $error("checker: result %h not congruent to 3*%h", result, op_a);
         // R4: all ones only for a nonzero multiple of the modulus
         p_zero_ones_r4: assert ((result == MOD[WIDTH-1:0]) ==
                                 (full_sum != '0 && (full_sum % MOD) == '0))
            else $error("checker: all-ones rule broken, sum %h", full_sum);
         // R4: all zeros only for a zero sum
         p_zero_zeros_r4: assert ((result == '0) == (full_sum == '0))
            else $error("checker: all-zeros rule broken, sum %h", full_sum);
      end
   end
endmodule

bind modm_triple_hmg modm_hmg_chk #(.WIDTH(WIDTH)) u_chk (
   .mode   (mode),
   .op_a   (op_a),
   .op_b   (op_b),
   .result (result)
);

// File: tb/modm_triple_hmg_tb_top.sv
module modm_triple_hmg_tb_top;
   localparam int W = 8;
   localparam logic [W-1:0] ONES = {W{1'b1}};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode;
   logic [W-1:0] op_a, op_b;
   logic [W-1:0] res_log, res_ser;
   int           n_chk = 0, n_fail = 0;
   bit           done = 1'b0;

   always #5 clk = ~clk;

   modm_triple_hmg #(.WIDTH(W), .PREFIX_ARCH(0)) dut_i (
      .mode(mode), .op_a(op_a), .op_b(op_b), .result(res_log));
   modm_triple_hmg #(.WIDTH(W), .PREFIX_ARCH(1)) dut_ser_i (
      .mode(mode), .op_a(op_a), .op_b(op_b), .result(res_ser));

   function automatic logic [W-1:0] rotl1(input logic [W-1:0] x);
      return {x[W-2:0], x[W-1]};
   endfunction

   function automatic logic [W-1:0] eac(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W:0] s;
      logic [W:0] r;
      s = {1'b0, a} + {1'b0, b};
      r = {1'b0, s[W-1:0]} + {{W{1'b0}}, s[W]};
      return r[W-1:0];
   endfunction

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h (mode=%0d a=%h b=%h)", req, got, exp, mode, op_a, op_b);
      end
   endtask

   task automatic apply(input logic m, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      mode = m; op_a = a; op_b = b;
      #1;
   endtask

   initial begin
      logic [W-1:0] first;
      void'($urandom(32'h5eed_0042));
      mode = 1'b0; op_a = '0; op_b = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R4 / R6: zero inputs give zero at once
      apply(1'b0, '0, '0);
      check("R4 zero triple", res_log, '0);
      apply(1'b1, '0, '0);
      check("R4 zero add", res_log, '0);
      // R4: all-ones operand is zero, stays all ones
      apply(1'b0, ONES, 8'h5a);
      check("R4 ones triple", res_log, ONES);
      apply(1'b1, ONES, ONES);
      check("R4 ones+ones", res_log, ONES);
      apply(1'b1, 8'h0f, 8'hf0);
      check("R4 sum equals modulus", res_log, ONES);
      apply(1'b1, 8'h01, ONES);
      check("R2 wrap carry", res_log, 8'h01);
      apply(1'b0, 8'h80, 8'h00);
      check("R1 top bit rotate", res_log, 8'h81);

      // R1 / R5: exhaustive triple sweep with random op_b
      for (int x = 0; x < (1 << W); x++) begin
         logic [W-1:0] xv;
         logic [W-1:0] e;
         xv = W'(x);
         apply(1'b0, xv, W'($urandom));
         e = eac(xv, rotl1(xv));
         check("R1 triple", res_log, e);
         check("R5 serial triple", res_ser, res_log);
         if ((32'(e) % 255) != ((3 * x) % 255)) begin
            n_chk++; n_fail++;
            $display("FAIL R1 congruence: got %h expected %0d mod 255", e, (3 * x) % 255);
         end
      end

      // R3: op_b varies, triple result unchanged
      for (int k = 0; k < 40; k++) begin
         logic [W-1:0] av;
         av = W'($urandom);
         apply(1'b0, av, 8'h00);
         first = res_log;
         apply(1'b0, av, W'($urandom));
         check("R3 op_b ignored", res_log, first);
      end

      // R2 / R5: random add mode
      for (int k = 0; k < 2000; k++) begin
         logic [W-1:0] av, bv;
         av = W'($urandom); bv = W'($urandom);
         apply(1'b1, av, bv);
         check("R2 add", res_log, eac(av, bv));
         check("R5 serial add", res_ser, res_log);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule